// File: doc/BRIEF.md
# Pipeline Hazard Detection and Operand Forwarding Unit

This block is the control logic that keeps a five-stage in-order integer pipeline producing correct results when one instruction needs a register that an older instruction has not yet written back. It looks at the two source register indices of the instruction in the execute stage. It compares them with the destination indices held in the two later pipeline registers: the one after execute, called MEM here, and the one after memory access, called WB here. From these comparisons it drives the select of each ALU operand multiplexer.

When a load sits in execute and the instruction right behind it, in decode, reads the load's destination, forwarding cannot deliver the value in time. The unit then asserts a stall, which freezes the PC and the fetch/decode register. It also asserts a bubble request, which makes the decode/execute register take an entry with every write and memory enable cleared. Because the load moves on to MEM in the next cycle, the hazard clears by itself and exactly one bubble is inserted. The datapath, the multiplexers and the register file lie outside this block. The unit is purely combinational.

Top module: `hz_fwd_unit`

## Requirements
- R1: An execute-stage source index that is nonzero, equal to mem_rd_i, with mem_we_i set and mem_load_i clear, selects the MEM path, encoded as 2'b10 on its select.
- R2: A nonzero source that does not take the MEM path, but equals wb_rd_i with wb_we_i set, selects the WB path, encoded 2'b01. In every other case the select is 2'b00, the register-file value.
- R3: When both the MEM and the WB entries qualify for the same source, the MEM path (2'b10) wins.
- R4: Source index 0 always selects 2'b00, and a decode-stage source of 0 never raises a stall.
- R5: A stage whose write enable is clear never supplies a forwarded value, whatever its destination index.
- R6: A load held in MEM is never forwarded from MEM. The select falls back to the WB path if that qualifies, otherwise to 2'b00.
- R7: stall_o and bubble_o are 1 when ex_load_i and ex_we_i are set, ex_rd_i is nonzero, and ex_rd_i equals id_rs1_i or id_rs2_i.
- R8: In all other cases stall_o and bubble_o are 0, and the two outputs are always equal.
- R9: Operand A (from ex_rs1_i) and operand B (from ex_rs2_i) are resolved independently by the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | First source index of the instruction in decode |
| id_rs2_i | input | REG_AW | Second source index of the instruction in decode |
| ex_rs1_i | input | REG_AW | First source index of the instruction in execute |
| ex_rs2_i | input | REG_AW | Second source index of the instruction in execute |
| ex_rd_i | input | REG_AW | Destination index of the instruction in execute |
| ex_we_i | input | 1 | Register write enable of the instruction in execute |
| ex_load_i | input | 1 | Instruction in execute is a load |
| mem_rd_i | input | REG_AW | Destination index held in the MEM pipeline register |
| mem_we_i | input | 1 | Register write enable held in the MEM pipeline register |
| mem_load_i | input | 1 | MEM pipeline register holds a load |
| wb_rd_i | input | REG_AW | Destination index held in the WB pipeline register |
| wb_we_i | input | 1 | Register write enable held in the WB pipeline register |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 01 WB, 10 MEM |
| fwd_b_o | output | 2 | Operand B select, same encoding |
| stall_o | output | 1 | Freeze PC and the fetch/decode register |
| bubble_o | output | 1 | Load a cleared entry into the decode/execute register |

## Verification
Forwarding and load-use detection can act in the same cycle. A load in execute can stall the decode instruction while the execute instruction's own operands are being forwarded from MEM and WB. The bench provokes this by driving the forwarding and load-use input fields at once in a sweep over a 2-bit index configuration. Both operand selects and the stall/bubble pair are compared every step against values the bench derives from the rules. The priority case, with both stages matching, and the write-disabled and load-in-MEM cases fall out of the same exhaustive enumeration.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output fwd_sel_e          sel_o
);
  logic src_live, mem_hit, wb_hit;

  assign src_live = |rs_i;
  // a load in MEM only holds its address, never its data
  assign mem_hit  = src_live && mem_we_i && !mem_load_i && (mem_rd_i == rs_i);
  assign wb_hit   = src_live && wb_we_i && (wb_rd_i == rs_i);

  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  always_comb begin
    if (rs_i == '0)
      assert_zero_src_R4: assert (sel_o == FWD_RF) else $error("zero source forwarded");
    if (mem_load_i)
      assert_no_load_mem_R6: assert (sel_o != FWD_MEM) else $error("load forwarded from MEM");
    if (!mem_we_i)
      assert_mem_we_R5: assert (sel_o != FWD_MEM) else $error("MEM forwarded without write");
    if (!wb_we_i)
      assert_wb_we_R5: assert (sel_o != FWD_WB) else $error("WB forwarded without write");
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [REG_AW-1:0] id_src_i [NUM_SRC],
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  output logic              hazard_o
);
  logic [NUM_SRC-1:0] src_hit;
  logic               producer_live;

  assign producer_live = ex_load_i && ex_we_i && (ex_rd_i != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign src_hit[g] = (id_src_i[g] == ex_rd_i);
  end

  assign hazard_o = producer_live && (|src_hit);

  always_comb begin
    if (hazard_o)
      assert_stall_src_R7: assert (ex_load_i && ex_rd_i != '0) else $error("stall without load producer");
  end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              stall_o,
  output logic              bubble_o
);
  localparam int NUM_SRC = 2;

  logic [REG_AW-1:0] ex_src [NUM_SRC];
  logic [REG_AW-1:0] id_src [NUM_SRC];
  fwd_sel_e          sel    [NUM_SRC];
  logic              load_hazard;

  assign ex_src[0] = ex_rs1_i;
  assign ex_src[1] = ex_rs2_i;
  assign id_src[0] = id_rs1_i;
  assign id_src[1] = id_rs2_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hz_src_match #(.REG_AW(REG_AW)) u_match (
      .rs_i       (ex_src[g]),
      .mem_rd_i   (mem_rd_i),
      .mem_we_i   (mem_we_i),
      .mem_load_i (mem_load_i),
      .wb_rd_i    (wb_rd_i),
      .wb_we_i    (wb_we_i),
      .sel_o      (sel[g])
    );
  end

  hz_load_use #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_load_use (
    .id_src_i  (id_src),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .hazard_o  (load_hazard)
  );

  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];
  assign stall_o  = load_hazard;
  assign bubble_o = load_hazard;

  always_comb begin
    if (fwd_a_o == FWD_MEM)
      assert_mem_index_R1: assert (mem_rd_i == ex_rs1_i && mem_rd_i != '0) else $error("MEM select index mismatch");
    if (fwd_b_o == FWD_WB)
      assert_wb_index_R2: assert (wb_rd_i == ex_rs2_i && wb_we_i) else $error("WB select index mismatch");
    if (!ex_load_i)
      assert_no_stall_R8: assert (!stall_o && !bubble_o) else $error("stall without load");
  end
endmodule

// File: tb/tb_hz_fwd_unit.sv
module tb_hz_fwd_unit;
  localparam int AW = 2;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_load, mem_we, mem_load, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hz_fwd_unit #(.REG_AW(AW)) dut (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_load_i(mem_load),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .bubble_o(bubble)
  );

  function automatic logic [1:0] exp_sel(int rs);
    if (rs == 0) return 2'b00;
    if (mem_we && !mem_load && int'(mem_rd) == rs) return 2'b10;
    if (wb_we && int'(wb_rd) == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(int rs);
    bit mm = (int'(mem_rd) == rs);
    bit wm = (int'(wb_rd) == rs);
    if (rs == 0) return "R4";
    if (mm && mem_we && !mem_load && wm && wb_we) return "R3";
    if (mm && mem_we && mem_load) return "R6";
    if ((mm && !mem_we) || (wm && !wb_we)) return "R5";
    if (mm && mem_we) return "R1";
    return "R2";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (rs1=%0d rs2=%0d mrd=%0d mwe=%0d mld=%0d wrd=%0d wwe=%0d id=%0d/%0d erd=%0d ewe=%0d eld=%0d)",
               tag, act, exp, ex_rs1, ex_rs2, mem_rd, mem_we, mem_load, wb_rd, wb_we,
               id_rs1, id_rs2, ex_rd, ex_we, ex_load);
    end
  endtask

  task automatic check_all();
    logic exp_st;
    @(negedge clk);
    chk(sel_tag(int'(ex_rs1)), int'(fwd_a), int'(exp_sel(int'(ex_rs1))));
    chk({"R9/", sel_tag(int'(ex_rs2))}, int'(fwd_b), int'(exp_sel(int'(ex_rs2))));
    exp_st = ex_load && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    if (exp_st) chk("R7 stall", int'(stall), 1);
    else if (ex_load && ex_we && (id_rs1 == 0 || id_rs2 == 0) && ex_rd == 0) chk("R4 stall", int'(stall), 0);
    else chk("R8 stall", int'(stall), 0);
    chk("R8 bubble", int'(bubble), int'(exp_st));
  endtask

  initial begin
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {ex_we, ex_load, mem_we, mem_load, wb_we} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: nothing in flight
    check_all();
    // forwarding sweep with a fixed load-use pattern cycling alongside
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int m = 0; m < NR; m++)
          for (int w = 0; w < NR; w++)
            for (int f = 0; f < 8; f++) begin
              @(posedge clk); #1;
              ex_rs1 = AW'(a); ex_rs2 = AW'(b); mem_rd = AW'(m); wb_rd = AW'(w);
              mem_we = f[0]; mem_load = f[1]; wb_we = f[2];
              ex_rd = AW'(a + w); id_rs1 = AW'(m); id_rs2 = AW'(b ^ f);
              ex_we = f[0] ^ f[2]; ex_load = f[1] | (a[0] & w[0]);
              check_all();
            end
    // load-use sweep, with forwarding inputs active at the same time
    for (int i1 = 0; i1 < NR; i1++)
      for (int i2 = 0; i2 < NR; i2++)
        for (int rd = 0; rd < NR; rd++)
          for (int f = 0; f < 4; f++) begin
            @(posedge clk); #1;
            id_rs1 = AW'(i1); id_rs2 = AW'(i2); ex_rd = AW'(rd);
            ex_we = f[0]; ex_load = f[1];
            ex_rs1 = AW'(rd); ex_rs2 = AW'(i1); mem_rd = AW'(rd); wb_rd = AW'(i1);
            mem_we = 1'b1; mem_load = f[0]; wb_we = 1'b1;
            check_all();
          end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule